// File: doc/BRIEF.md
# Scanline Memory Slot Arbiter

This block decides, once per memory cycle, which requester owns the shared memory bus. It keeps its own horizontal position counter that steps through the cycle slots of one scanline and wraps at a parameterised line length. Early slots are tied to fixed channels by position: DRAM refresh, disk, four audio channels and eight sprites. A configurable window in the middle of the line belongs to bitplane fetch while the display window flag is high. Whatever is left goes to a display-list coprocessor, then to the block-transfer engine (blitter) and the CPU. The blitter and the CPU normally share the free cycles by slot parity. A hog control bit hands every free cycle to the blitter.

Each cycle the block decides for the slot about to start and registers the result. The grant therefore appears together with the slot number it belongs to. A requester that is idle or disabled in its own slot gives that slot to the next eligible requester in the fixed order. The CPU wait output tells the processor side that its request was refused for the current slot.

Top module: `slot_arbiter`

## Requirements
- R1: After a synchronous reset `hpos_o` is 0, `grant_o` is all zero and `cpu_wait_o` is 0. On each clock edge out of reset `hpos_o` steps by one and wraps from LINE_LEN-1 to 0. `grant_o` and `cpu_wait_o` belong to the slot shown in `hpos_o` and are decided from the inputs sampled at the same edge that loads that slot number.
- R2: Refresh (request/enable bit 0) may win only slots 0, 2 and 4.
- R3: Disk (bit 1) may win only slots 1, 3 and 5.
- R4: Audio channel k (bit 2+k, k = 0..3) may win only slot 7+2k.
- R5: Sprite n (bit 6+n, n = 0..7) may win only slots 15+4n and 17+4n.
- R6: Bitplane fetch (bit 14) may win only when `disp_win_i` is high and the slot lies between BPL_START and BPL_STOP, both ends included (defaults 0x38 and 0xD0).
- R7: When several requesters are eligible, the lowest bit index wins. The order runs refresh, disk, audio, sprites, bitplanes, coprocessor (bit 15), blitter (bit 16), CPU (bit 17). The coprocessor is eligible in any slot.
- R8: A requester takes part only when both its request and enable bits are high. A fixed slot whose owner is idle or disabled goes to the next eligible requester, and a channel is never granted outside its own slots.
- R9: With hog low, an even slot goes to the blitter ahead of the CPU and an odd slot goes to the CPU ahead of the blitter. If one of the two is inactive, the other takes the slot.
- R10: With `blt_hog_i` high and the blitter active, the blitter may take any free slot and the CPU is never granted.
- R11: `cpu_wait_o` is high exactly when the CPU request bit was high and `grant_o` bit 17 is low for that slot.
- R12: At most one bit of `grant_o` is set in any cycle. All zero means the slot is unused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one memory slot per cycle |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 18 | Request per requester, bit order as in R2 to R10 |
| en_i | input | 18 | Enable per requester, same bit order |
| disp_win_i | input | 1 | Display window active |
| blt_hog_i | input | 1 | Blitter takes every free slot |
| hpos_o | output | HPOS_W | Current slot number in the line |
| grant_o | output | 18 | One-hot owner of the current slot |
| cpu_wait_o | output | 1 | CPU requested but was refused this slot |

## Verification
The clashes that matter are a fixed-slot owner against the coprocessor, blitter and CPU in the same slot, and the blitter and CPU against each other on a free slot, with and without hog. The bench raises every request at once and holds them for whole lines. It then disables the fixed owners while their requests stay high, runs the blitter alone and the CPU alone, and finishes with random request, enable, window and hog patterns. Every slot's expected owner and wait flag come from a priority model in the bench and are compared against the registered outputs.

// File: rtl/slot_arb_pkg.sv
package slot_arb_pkg;
  localparam int NCH     = 18;
  localparam int CH_REF  = 0;
  localparam int CH_DSK  = 1;
  localparam int CH_AUD0 = 2;
  localparam int NAUD    = 4;
  localparam int CH_SPR0 = 6;
  localparam int NSPR    = 8;
  localparam int CH_BPL  = 14;
  localparam int CH_COP  = 15;
  localparam int CH_BLT  = 16;
  localparam int CH_CPU  = 17;
  localparam int NFIX    = CH_BPL;
  localparam int AUD_BASE = 7;
  localparam int SPR_BASE = 15;
  localparam int SPR_LAST = SPR_BASE + 4 * NSPR - 2;

  // Channel that owns a position-reserved slot, or -1 when the slot is free.
  function automatic int slot_owner(input int s);
    int r;
    r = -1;
    if (s <= 5)
      r = (s % 2 == 0) ? CH_REF : CH_DSK;
    else if (s >= AUD_BASE && s < AUD_BASE + 2 * NAUD && (s % 2 == 1))
      r = CH_AUD0 + (s - AUD_BASE) / 2;
    else if (s >= SPR_BASE && s <= SPR_LAST && (s % 2 == 1))
      r = CH_SPR0 + (s - SPR_BASE) / 4;
    return r;
  endfunction
endpackage

// File: rtl/slot_line_counter.sv
module slot_line_counter #(
  parameter int LINE_LEN = 227,
  parameter int HPOS_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [HPOS_W-1:0] hpos_q,
  output logic [HPOS_W-1:0] hpos_next
);
  localparam logic [HPOS_W-1:0] LAST = HPOS_W'(LINE_LEN - 1);

  always_comb
    hpos_next = (hpos_q == LAST) ? '0 : hpos_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) hpos_q <= '0;
    else     hpos_q <= hpos_next;
  end

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (hpos_q == LAST) |=> (hpos_q == '0));
endmodule

// File: rtl/slot_eligibility.sv
module slot_eligibility
  import slot_arb_pkg::*;
#(
  parameter int HPOS_W    = 8,
  parameter int BPL_START = 'h38,
  parameter int BPL_STOP  = 'hD0
) (
  input  logic [HPOS_W-1:0] slot,
  input  logic [NCH-1:0]    req,
  input  logic [NCH-1:0]    en,
  input  logic              win,
  input  logic              hog,
  output logic [NCH-1:0]    elig
);
  logic [NCH-1:0] act;
  int             owner;
  logic           in_bpl;

  assign act = req & en;

  always_comb begin
    owner  = slot_owner(int'(slot));
    in_bpl = (int'(slot) >= BPL_START) && (int'(slot) <= BPL_STOP);
  end

  genvar i;
  generate
    for (i = 0; i < NFIX; i++) begin : g_fixed
      assign elig[i] = act[i] && (owner == i);
    end
  endgenerate

  assign elig[CH_BPL] = act[CH_BPL] && win && in_bpl;
  assign elig[CH_COP] = act[CH_COP];
  assign elig[CH_BLT] = act[CH_BLT] && (hog || !slot[0] || !act[CH_CPU]);
  assign elig[CH_CPU] = act[CH_CPU] && !(hog && act[CH_BLT])
                        && (slot[0] || !act[CH_BLT]);

  // R9
  parity_chk: assert final (!(elig[CH_BLT] && elig[CH_CPU]));
endmodule

// File: rtl/slot_priority_pick.sv
module slot_priority_pick #(
  parameter int N = 18
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] pick
);
  logic [N:0] taken;

  assign taken[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_chain
      assign pick[i]    = elig[i] && !taken[i];
      assign taken[i+1] = taken[i] || elig[i];
    end
  endgenerate
endmodule

// File: rtl/slot_arbiter.sv
module slot_arbiter
  import slot_arb_pkg::*;
#(
  parameter int LINE_LEN  = 227,
  parameter int BPL_START = 'h38,
  parameter int BPL_STOP  = 'hD0,
  localparam int HPOS_W   = $clog2(LINE_LEN)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req_i,
  input  logic [NCH-1:0]    en_i,
  input  logic              disp_win_i,
  input  logic              blt_hog_i,
  output logic [HPOS_W-1:0] hpos_o,
  output logic [NCH-1:0]    grant_o,
  output logic              cpu_wait_o
);
  logic [HPOS_W-1:0] hpos_next;
  logic [NCH-1:0]    elig;
  logic [NCH-1:0]    pick;

  slot_line_counter #(.LINE_LEN(LINE_LEN), .HPOS_W(HPOS_W)) u_cnt (
    .clk(clk), .rst(rst), .hpos_q(hpos_o), .hpos_next(hpos_next));

  slot_eligibility #(.HPOS_W(HPOS_W), .BPL_START(BPL_START), .BPL_STOP(BPL_STOP)) u_elig (
    .slot(hpos_next), .req(req_i), .en(en_i), .win(disp_win_i),
    .hog(blt_hog_i), .elig(elig));

  slot_priority_pick #(.N(NCH)) u_pick (.elig(elig), .pick(pick));

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_o    <= '0;
      cpu_wait_o <= 1'b0;
    end else begin
      grant_o    <= pick;
      cpu_wait_o <= req_i[CH_CPU] && !pick[CH_CPU];
    end
  end

  // R12
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_o));
  // R11
  wait_excl_chk: assert property (@(posedge clk) disable iff (rst)
    cpu_wait_o |-> !grant_o[CH_CPU]);
  // R10
  hog_block_chk: assert property (@(posedge clk) disable iff (rst)
    (blt_hog_i && req_i[CH_BLT] && en_i[CH_BLT]) |=> !grant_o[CH_CPU]);
  // R2
  refresh_slot_chk: assert property (@(posedge clk) disable iff (rst)
    grant_o[CH_REF] |-> (hpos_o == 0 || hpos_o == 2 || hpos_o == 4));
  // R8
  disabled_chk: assert property (@(posedge clk) disable iff (rst)
    (en_i == '0) |=> (grant_o == '0));
endmodule

// File: tb/tb_slot_arbiter.sv
module tb_slot_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int LEN = 227;
  localparam int HW  = $clog2(LEN);

  typedef struct {
    int        slot;
    int        owner;
    bit        wt;
    string     tag;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [17:0]   req_i = '0;
  logic [17:0]   en_i = '0;
  logic          disp_win_i = 1'b0;
  logic          blt_hog_i = 1'b0;
  logic [HW-1:0] hpos_o;
  logic [17:0]   grant_o;
  logic          cpu_wait_o;

  exp_t q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  int   exp_slot = 0;
  bit   done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_arbiter dut (.clk(clk), .rst(rst), .req_i(req_i), .en_i(en_i),
    .disp_win_i(disp_win_i), .blt_hog_i(blt_hog_i), .hpos_o(hpos_o),
    .grant_o(grant_o), .cpu_wait_o(cpu_wait_o));

  function automatic int model(int s, bit [17:0] r, bit [17:0] e, bit w, bit h);
    bit [17:0] a;
    a = r & e;
    if (a[0] && (s == 0 || s == 2 || s == 4)) return 0;
    if (a[1] && (s == 1 || s == 3 || s == 5)) return 1;
    for (int k = 0; k < 4; k++) if (a[2+k] && s == 7 + 2*k) return 2 + k;
    for (int k = 0; k < 8; k++)
      if (a[6+k] && (s == 15 + 4*k || s == 17 + 4*k)) return 6 + k;
    if (a[14] && w && s >= 'h38 && s <= 'hD0) return 14;
    if (a[15]) return 15;
    if (h && a[16]) return 16;
    if (s % 2 == 0) begin
      if (a[16]) return 16;
      if (a[17]) return 17;
    end else begin
      if (a[17]) return 17;
      if (a[16]) return 16;
    end
    return -1;
  endfunction

  function automatic string tag_of(int o, bit h);
    if (o == 0) return "R2";
    if (o == 1) return "R3";
    if (o >= 2 && o <= 5) return "R4";
    if (o >= 6 && o <= 13) return "R5";
    if (o == 14) return "R6";
    if (o == 15) return "R7";
    if (o == 16) return h ? "R10" : "R9";
    if (o == 17) return "R9";
    return "R8";
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // driver: apply inputs at a falling edge and predict the next slot
  task automatic step(bit [17:0] r, bit [17:0] e, bit w, bit h, string force_tag);
    exp_t it;
    req_i = r; en_i = e; disp_win_i = w; blt_hog_i = h;
    exp_slot = (exp_slot + 1) % LEN;
    it.slot  = exp_slot;
    it.owner = model(exp_slot, r, e, w, h);
    it.wt    = r[17] && (it.owner != 17);
    it.tag   = (force_tag != "") ? force_tag : tag_of(it.owner, h);
    q.push_back(it);
    @(negedge clk);
  endtask

  // monitor: compare registered outputs just after each rising edge
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t it;
      logic [17:0] eg;
      it = q.pop_front();
      eg = (it.owner < 0) ? 18'd0 : (18'd1 << it.owner);
      check(int'(hpos_o) == it.slot, "R1", "hpos", int'(hpos_o), it.slot);
      check(grant_o == eg, it.tag, "grant", int'(grant_o), int'(eg));
      check(cpu_wait_o == it.wt, "R11", "cpu_wait", int'(cpu_wait_o), int'(it.wt));
      check($countones(grant_o) <= 1, "R12", "grant ones", $countones(grant_o), 1);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_bad++;
    $display("FAIL R1 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(hpos_o == '0, "R1", "reset hpos", int'(hpos_o), 0);
    check(grant_o == '0, "R1", "reset grant", int'(grant_o), 0);
    check(cpu_wait_o == 1'b0, "R1", "reset wait", int'(cpu_wait_o), 0);
    rst = 1'b0;
    exp_slot = 0;
    // R7 everyone requesting, window on, hog off
    for (int i = 0; i < 2 * LEN; i++) step('1, '1, 1'b1, 1'b0, "");
    // R10 everyone requesting with hog
    for (int i = 0; i < LEN; i++) step('1, '1, 1'b0, 1'b1, "");
    // R8 fixed owners requesting but disabled
    for (int i = 0; i < LEN; i++) step('1, 18'h3C000, 1'b1, 1'b0, "");
    // R9 blitter and CPU only, then each alone
    for (int i = 0; i < LEN; i++) step(18'h30000, '1, 1'b0, 1'b0, "");
    for (int i = 0; i < 40; i++) step(18'h10000, '1, 1'b0, 1'b0, "");
    for (int i = 0; i < 40; i++) step(18'h20000, '1, 1'b0, 1'b0, "");
    // R10 hog with blitter idle leaves CPU every slot
    for (int i = 0; i < 40; i++) step(18'h20000, '1, 1'b0, 1'b1, "");
    // R8 nothing enabled
    for (int i = 0; i < 20; i++) step('1, '0, 1'b1, 1'b0, "R8");
    // mixed random patterns
    for (int i = 0; i < 3000; i++)
      step(18'($urandom), 18'($urandom) | 18'h3C000, 1'($urandom), 1'($urandom), "");
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule